// File: doc/BRIEF.md
# Frame-Based Shift Automatic Gain Control

This block sits in a receive path and scales a stream of signed I/Q samples by a power of two. The amount is set by a signed gain. A positive gain shifts left, and a negative gain shifts right arithmetically. Results that leave the output range are clipped to it. Over each frame, delimited by a one-cycle boundary pulse, the block records two statistics: the largest post-scaling magnitude and the number of clipped samples.

At each boundary the statistics are latched into a status word and the running accumulators restart. When the loop is enabled, the gain is then stepped:
- It steps down by the attack amount when the frame clipped or overshot the target peak.
- It steps up by the decay amount once the holdoff count of quiet frames has run out.

When the loop is disabled, the gain tracks a manually programmed value. A separate flag tells an outer control loop that the last frame saturated.

Top module: `shift_agc`

## Requirements
- R1: The gain is a signed 4-bit value kept within -7..+7. A manual value of -8 is taken as -7. The gain appears in status bits [27:24] in two's complement.
- R2: Each sample is scaled by the current gain, and the result appears one cycle later. Positive gain g multiplies by 2^g. Negative gain g performs an arithmetic right shift by -g, which rounds toward minus infinity. out_valid equals in_valid delayed by one cycle.
- R3: A scaled result above 32767 is clipped to 32767, and one below -32768 is clipped to -32768. A valid sample with a clip on either lane adds one to the frame's saturation count. The count stops at 255.
- R4: The frame peak is the largest magnitude of the scaled I or Q value over the valid samples of the frame. The magnitude of -32768 is 32768. At each boundary, the peak and count are latched and the accumulators restart from zero.
- R5: A valid sample that arrives in the same cycle as the boundary pulse belongs to the frame that is closing.
- R6: The status word is laid out as follows: [28] enable, [27:24] gain, [23:16] saturation count of the last frame, [15:0] peak of the last frame. The count and peak change only on a boundary.
- R7: sat_flag is high exactly when the last closed frame had a nonzero saturation count.
- R8: The enable resets to off, and reset clears all state. While disabled, the gain loads the manual value every cycle, and boundary pulses do not alter the gain.
- R9: With the loop enabled, a boundary whose frame clipped, or whose peak exceeds the target, lowers the gain by the attack step (0..7). The result is clamped at -7, and the holdoff counter reloads from the holdoff setting.
- R10: With the loop enabled, a boundary whose peak is below the target and whose holdoff counter is zero raises the gain by the decay step, clamped at +7. In any other case the gain is unchanged, and a nonzero holdoff counter drops by one.
- R11: Gain arithmetic sign-extends the 4-bit gain. For example, -2 raised by 1 gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Input I sample, signed |
| in_q | input | DW | Input Q sample, signed |
| frame_tick | input | 1 | Frame boundary pulse |
| agc_en | input | 1 | Loop enable |
| target | input | DW | Target peak magnitude |
| attack | input | 3 | Gain decrement step |
| decay | input | 3 | Gain increment step |
| holdoff | input | HW | Quiet frames to wait before rising |
| manual_gain | input | 4 | Gain used while disabled, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | Scaled I, signed |
| out_q | output | DW | Scaled Q, signed |
| stat_word | output | DW+CW+5 | Status: enable, gain, count, peak |
| sat_flag | output | 1 | Last frame saturated |

## Verification
Scaled samples and out_valid are due one clock edge after the sample is presented. The peak, count, gain step and sat_flag of a frame are due one edge after its boundary pulse. A manual gain takes effect on the edge after it is driven, so a sample scaled by that gain goes in one cycle later. The bench drives every stimulus on a falling edge and reads results on the following falling edge, which places each check exactly one register stage after its cause.

// File: rtl/shift_agc.sv
module shift_agc #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int HW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_i,
  input  logic [DW-1:0]       in_q,
  input  logic                frame_tick,
  input  logic                agc_en,
  input  logic [DW-1:0]       target,
  input  logic [2:0]          attack,
  input  logic [2:0]          decay,
  input  logic [HW-1:0]       holdoff,
  input  logic [3:0]          manual_gain,
  output logic                out_valid,
  output logic [DW-1:0]       out_i,
  output logic [DW-1:0]       out_q,
  output logic [DW+CW+4:0]    stat_word,
  output logic                sat_flag
);
  localparam int WW = DW + 8;
  localparam logic signed [WW-1:0] HI = {{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [WW-1:0] LO = {{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic [DW:0] scale(input logic [DW-1:0] x, input logic [3:0] g);
    logic signed [WW-1:0] w;
    logic [3:0] sh;
    w = {{(WW-DW){x[DW-1]}}, x};
    sh = 4'(-g);
    if (g[3]) w = w >>> sh;
    else      w = w <<< g[2:0];
    if (w > HI) return {1'b1, HI[DW-1:0]};
    if (w < LO) return {1'b1, LO[DW-1:0]};
    return {1'b0, w[DW-1:0]};
  endfunction

  function automatic logic [DW-1:0] mag(input logic [DW-1:0] x);
    return x[DW-1] ? DW'(-x) : x;
  endfunction

  logic [3:0]    gain;
  logic [HW-1:0] hold;
  logic [DW-1:0] pk_acc, pk_last;
  logic [CW-1:0] sat_acc, sat_last;

  logic [DW:0]   si, sq;
  logic [DW-1:0] mi, mq, smag, pk_nxt;
  logic [CW-1:0] sat_nxt;
  logic          clip, over, under;
  logic signed [5:0] gx, dn, up;
  logic [3:0]    dn_cl, up_cl, man_cl;

  assign si    = scale(in_i, gain);
  assign sq    = scale(in_q, gain);
  assign clip  = si[DW] | sq[DW];
  assign mi    = mag(si[DW-1:0]);
  assign mq    = mag(sq[DW-1:0]);
  assign smag  = (mi > mq) ? mi : mq;

  assign pk_nxt  = (in_valid && smag > pk_acc) ? smag : pk_acc;
  assign sat_nxt = (in_valid && clip && sat_acc != '1) ? sat_acc + 1'b1 : sat_acc;

  assign over  = (sat_nxt != '0) || (pk_nxt > target);
  assign under = pk_nxt < target;

  assign gx    = {{2{gain[3]}}, gain};
  assign dn    = gx - $signed({3'b000, attack});
  assign up    = gx + $signed({3'b000, decay});
  assign dn_cl = (dn < -6'sd7) ? 4'b1001 : dn[3:0];
  assign up_cl = (up >  6'sd7) ? 4'b0111 : up[3:0];
  assign man_cl = (manual_gain == 4'b1000) ? 4'b1001 : manual_gain;

  assign stat_word = {agc_en, gain, sat_last, pk_last};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      pk_acc    <= '0;
      pk_last   <= '0;
      sat_acc   <= '0;
      sat_last  <= '0;
      sat_flag  <= 1'b0;
      gain      <= '0;
      hold      <= '0;
    end else begin
      out_valid <= in_valid;
      out_i     <= si[DW-1:0];
      out_q     <= sq[DW-1:0];
      if (frame_tick) begin
        pk_last  <= pk_nxt;
        sat_last <= sat_nxt;
        sat_flag <= sat_nxt != '0;
        pk_acc   <= '0;
        sat_acc  <= '0;
      end else begin
        pk_acc  <= pk_nxt;
        sat_acc <= sat_nxt;
      end
      if (!agc_en) begin
        gain <= man_cl;
        hold <= '0;
      end else if (frame_tick) begin
        if (over) begin
          gain <= dn_cl;
          hold <= holdoff;
        end else if (under && hold == '0) begin
          gain <= up_cl;
        end else if (hold != '0) begin
          hold <= hold - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shift_agc_chk.sv
module shift_agc_chk #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             frame_tick,
  input logic             agc_en,
  input logic [3:0]       manual_gain,
  input logic [DW+CW+4:0] stat_word,
  input logic             sat_flag
);
  localparam int GT = DW + CW;

  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_gain_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[GT+3:GT] != 4'b1000);
  p_manual_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!agc_en && manual_gain != 4'b1000) |=> stat_word[GT+3:GT] == $past(manual_gain));
  p_stats_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(stat_word[GT-1:0]));
  p_gain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && !frame_tick) |=> $stable(stat_word[GT+3:GT]));
  p_flag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> sat_flag == (stat_word[GT-1:DW] != '0));
endmodule

bind shift_agc shift_agc_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .frame_tick(frame_tick), .agc_en(agc_en), .manual_gain(manual_gain),
  .stat_word(stat_word), .sat_flag(sat_flag)
);

// File: tb/shift_agc_tb_top.sv
`timescale 1ns/1ps
module shift_agc_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, frame_tick = 0, agc_en = 0;
  logic [15:0] in_i = 0, in_q = 0, target = 0;
  logic [2:0] attack = 0, decay = 0;
  logic [3:0] holdoff = 0, manual_gain = 0;
  logic out_valid, sat_flag;
  logic [15:0] out_i, out_q;
  logic [28:0] stat_word;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shift_agc dut_i (.clk, .rst_n, .in_valid, .in_i, .in_q, .frame_tick, .agc_en,
    .target, .attack, .decay, .holdoff, .manual_gain, .out_valid, .out_i, .out_q,
    .stat_word, .sat_flag);

  // {clip, gain, input, expected output}
  localparam logic [36:0] VEC [10] = '{
    {1'b0,  4'sd0,  16'sd1000,   16'sd1000},
    {1'b0,  4'sd3,  16'sd1000,   16'sd8000},
    {1'b0,  4'sd7,  16'sd100,    16'sd12800},
    {1'b1,  4'sd7,  16'sd1000,   16'sd32767},
    {1'b0, -4'sd2, -16'sd1000,  -16'sd250},
    {1'b0, -4'sd7, -16'sd1000,  -16'sd8},
    {1'b1,  4'sd1, -16'sd20000, -16'sd32768},
    {1'b0, -4'sd1,  16'sd7,      16'sd3},
    {1'b0, -4'sd8,  16'sd12800,  16'sd100},
    {1'b0,  4'sd4, -16'sd2048,  -16'sd32768}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gain_now();
    return int'($signed(stat_word[27:24]));
  endfunction

  task automatic sample(input logic v, input int i, input int q, input logic tick);
    @(negedge clk);
    in_valid = v; in_i = 16'(i); in_q = 16'(q); frame_tick = tick;
    @(negedge clk);
    in_valid = 0; frame_tick = 0;
  endtask

  task automatic set_gain(input int g);
    @(negedge clk);
    manual_gain = 4'(g);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset status", int'(stat_word), 0);
    chk("R7 reset flag", int'(sat_flag), 0);
    chk("R2 reset valid", int'(out_valid), 0);
    rst_n = 1;

    for (int k = 0; k < 10; k++) begin
      logic [36:0] v;
      int y, pk;
      v = VEC[k];
      y = int'($signed(v[15:0]));
      pk = (y < 0) ? -y : y;
      set_gain(int'($signed(v[35:32])));
      sample(1, int'($signed(v[31:16])), 0, 1);
      chk("R2 valid", int'(out_valid), 1);
      chk("R2 R3 scaled I", int'($signed(out_i)), y);
      chk("R2 scaled Q", int'($signed(out_q)), 0);
      chk("R4 R5 peak", int'(stat_word[15:0]), pk);
      chk("R3 R5 count", int'(stat_word[23:16]), int'(v[36]));
      chk("R7 flag", int'(sat_flag), int'(v[36]));
      chk("R1 manual gain", gain_now(), (v[35:32] == 4'b1000) ? -7 : int'($signed(v[35:32])));
    end

    set_gain(0);
    sample(1, 100, 0, 0);
    sample(1, 0, -3000, 0);
    chk("R4 peak stable mid-frame R6", int'(stat_word[15:0]), 32768);
    sample(1, 500, 0, 0);
    sample(0, 0, 0, 1);
    chk("R2 idle valid", int'(out_valid), 0);
    chk("R4 multi-sample peak", int'(stat_word[15:0]), 3000);
    chk("R3 no clips", int'(stat_word[23:16]), 0);

    set_gain(7);
    sample(1, 1000, 0, 0);
    sample(1, 0, 1000, 0);
    sample(1, 10, 0, 0);
    sample(0, 0, 0, 1);
    chk("R3 clip count both lanes", int'(stat_word[23:16]), 2);
    chk("R7 flag set", int'(sat_flag), 1);
    sample(0, 0, 0, 1);
    chk("R4 empty frame peak", int'(stat_word[15:0]), 0);
    chk("R7 flag cleared", int'(sat_flag), 0);

    set_gain(0);
    @(negedge clk);
    target = 1000; attack = 2; decay = 1; holdoff = 2; agc_en = 1;
    sample(1, 5000, 0, 1);
    chk("R9 attack", gain_now(), -2);
    chk("R6 enable bit", int'(stat_word[28]), 1);
    sample(1, 100, 0, 1);
    chk("R10 holdoff 2", gain_now(), -2);
    sample(0, 0, 0, 1);
    chk("R10 holdoff 1", gain_now(), -2);
    sample(0, 0, 0, 1);
    chk("R11 sign-extended decay", gain_now(), -1);
    sample(0, 0, 0, 1);
    chk("R10 decay to 0", gain_now(), 0);
    @(negedge clk);
    target = 100;
    sample(1, 100, 0, 1);
    chk("R10 peak equal target", gain_now(), 0);
    @(negedge clk);
    target = 1000;
    sample(0, 0, 0, 1);
    chk("R10 decay to 1", gain_now(), 1);
    @(negedge clk);
    attack = 7; target = 10; holdoff = 0;
    sample(1, 30000, 0, 1);
    chk("R9 attack on clip", gain_now(), -6);
    chk("R7 flag on clip", int'(sat_flag), 1);
    sample(1, 32767, 0, 1);
    chk("R9 clamp -7", gain_now(), -7);
    @(negedge clk);
    decay = 7; target = 30000;
    sample(0, 0, 0, 1);
    chk("R10 decay 7", gain_now(), 0);
    sample(0, 0, 0, 1);
    chk("R10 decay to 7", gain_now(), 7);
    sample(0, 0, 0, 1);
    chk("R10 clamp +7", gain_now(), 7);

    @(negedge clk);
    agc_en = 0; manual_gain = 3;
    @(negedge clk);
    chk("R8 manual after disable", gain_now(), 3);
    sample(1, 30000, 0, 1);
    chk("R8 boundary ignored", gain_now(), 3);
    chk("R7 flag while disabled", int'(sat_flag), 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule